// File: doc/BRIEF.md
# Three-wire serial time/calendar access port

This block is the slave side of a three-wire serial link into a time-of-day and calendar counter. A host controls it with four pins: a select line, a direction line, a serial clock and one data line. While the select line is high, the direction line decides whether the host reads the counters or writes them. Every transfer carries a fixed 52-bit frame, least significant bit first. The fields, in order, are seconds, minutes, hours, a 4-bit weekday, day of month, month and year. The top bit of the seconds byte carries a low-supply flag, and the top bit of the month byte carries a test bit.

The counters and the divider that feeds them sit outside this block.

- **Read.** The first serial clock of a read copies a snapshot of the counters into a shift register. Each serial clock then presents one bit on the data output.
- **Write.** The port shifts in the host's bits and hands the complete frame to the counters in a single commit pulse.
- **Counter control during a write.** The port asks the divider to reset for a short window, and it stops seconds carries until the select line drops.
- **Other outputs.** A pulse marks a completed full-length read, so the low-supply flag can be cleared. A second pulse marks the fall of the select line, so the test bit can be cleared.

The serial pins are sampled on a fast system clock. Input filtering and synchronisation happen before this block.

Top module: `rtc_serial_port`

## Requirements
- R1: While `sel` is low, `sdo_oe` is 0, the bit position returns to zero, and activity on `sclk`, `dir` and `sdi` produces no commit pulse, no full-read pulse and no change to `carry_hold` or `div_clear`.
- R2: `sdo_oe` is 1 exactly when `sel` is 1 and `dir` is 0 (read mode); in write mode (`dir` = 1) it is 0.
- R3: Frame bit i is the i-th bit on the wire. Seconds occupy bits [7:0] with the low-supply flag at bit 7, minutes [15:8], hours [23:16], weekday [27:24], day [35:28], month [43:36] with the test bit at bit 43, and year [51:44].
- R4: In read mode, the first rising `sclk` edge loads `snap_in` and drives frame bit 0 on `sdo`. Rising edge k (k ≤ 52) drives frame bit k−1.
- R5: In read mode, rising `sclk` edges after the 52nd leave `sdo` unchanged, showing frame bit 51.
- R6: `full_read` pulses for one cycle on the 52nd rising edge of a read. A read ended earlier, for example after 28 edges, gives no pulse.
- R7: In write mode, `sdi` is sampled on each rising `sclk` edge. On the 52nd edge `load_pulse` pulses once, with `load_data` equal to the received frame. Bits from the 53rd edge onward change neither `load_data` nor the pulse count.
- R8: A write ended by `sel` falling before the 52nd rising edge produces no `load_pulse`.
- R9: In write mode, `div_clear` rises on the first falling `sclk` edge and drops on the second rising edge.
- R10: In write mode, `carry_hold` rises on the first falling `sclk` edge and stays high until `sel` goes low.
- R11: `test_clr` pulses for one cycle when `sel` goes from 1 to 0.
- R12: After reset, `sdo_oe`, `sdo`, `load_pulse`, `full_read`, `carry_hold`, `div_clear` and `test_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Select line; high enables a transfer |
| dir | input | 1 | Direction: 1 = host writes, 0 = host reads |
| sclk | input | 1 | Serial clock from the host, already synchronised |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the data pad driver |
| snap_in | input | 52 | Live counter frame, bit i = i-th bit on the wire |
| load_data | output | 52 | Received frame, valid while `load_pulse` is high |
| load_pulse | output | 1 | One-cycle commit of `load_data` into the counters |
| carry_hold | output | 1 | Stops seconds carries during a write |
| div_clear | output | 1 | Resets the sub-second divider |
| full_read | output | 1 | One-cycle pulse after a complete 52-bit read |
| test_clr | output | 1 | One-cycle pulse when `sel` falls, clears the test bit |

## Verification
The bench builds the port with its default frame width of 52. This exposes the real saturation point, the 28-edge partial read and the 52nd-edge commit exactly as the counters would see them. Several frame patterns are shifted both ways: all ones, a single set bit at either end, and mixed values. Because of this, an off-by-one in the bit position or a reversed shift direction shows up directly in the data. Truncated transfers, clocks beyond the frame end and pin activity while deselected are all exercised to show that the commit, clear and flag-report pulses fire only at their intended edges.

// File: rtl/rtc_serial_port.sv
module rtc_serial_port #(
  parameter int FRAME_W = 52
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               dir,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdo_oe,
  input  logic [FRAME_W-1:0] snap_in,
  output logic [FRAME_W-1:0] load_data,
  output logic               load_pulse,
  output logic               carry_hold,
  output logic               div_clear,
  output logic               full_read,
  output logic               test_clr
);

  localparam int CW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic               sclk_q, sel_q;
  logic [CW-1:0]      pos;
  logic [FRAME_W-1:0] shreg;
  logic               rise, fall, more;

  assign rise      = sel & sclk & ~sclk_q;
  assign fall      = sel & ~sclk & sclk_q;
  assign more      = pos < FULL;
  assign sdo_oe    = sel & ~dir;
  assign sdo       = sdo_oe & shreg[0];
  assign load_data = shreg;
  assign test_clr  = sel_q & ~sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      sel_q      <= 1'b0;
      pos        <= '0;
      shreg      <= '0;
      load_pulse <= 1'b0;
      full_read  <= 1'b0;
      carry_hold <= 1'b0;
      div_clear  <= 1'b0;
    end else begin
      sclk_q     <= sclk;
      sel_q      <= sel;
      load_pulse <= 1'b0;
      full_read  <= 1'b0;
      if (!sel) begin
        pos        <= '0;
        carry_hold <= 1'b0;
        div_clear  <= 1'b0;
      end else if (dir) begin
        if (rise && more) begin
          shreg <= {sdi, shreg[FRAME_W-1:1]};
          pos   <= pos + ONE;
          if (pos == LAST) load_pulse <= 1'b1;
          if (pos == ONE)  div_clear  <= 1'b0;
        end
        if (fall && pos == ONE && !carry_hold) begin
          carry_hold <= 1'b1;
          div_clear  <= 1'b1;
        end
      end else if (rise && more) begin
        pos <= pos + ONE;
        if (pos == '0) shreg <= snap_in;
        else           shreg <= shreg >> 1;
        if (pos == LAST) full_read <= 1'b1;
      end
    end
  end

  // R1
  deselect_clears_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (pos == '0));

  // R1
  deselect_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (!carry_hold && !div_clear));

  // R5
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= FULL);

  // R5
  read_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !dir && $past(sel && !dir && pos == FULL)) |-> $stable(sdo));

  // R6
  full_read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_read |-> $past(sel && !dir && rise));

  // R7
  load_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> (pos == FULL));

  // R9
  div_within_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_clear |-> carry_hold);

  // R10
  hold_only_writing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry_hold) |-> $past(sel && dir));

endmodule

// File: tb/test_rtc_serial_port.sv
module test_rtc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 52;
  localparam int NV = 5;
  localparam logic [W-1:0] VEC [NV] = '{
    52'h1234567890ABC, 52'hFFFFFFFFFFFFF, 52'h0000000000001,
    52'h8000000000000, 52'hA5A5A5A5A5A5A };

  logic clk = 0, rst_n = 0, sel = 0, dir = 0, sclk = 0, sdi = 0;
  logic [W-1:0] snap_in = '0;
  logic sdo, sdo_oe, load_pulse, carry_hold, div_clear, full_read, test_clr;
  logic [W-1:0] load_data;
  int n_chk = 0, n_fail = 0, n_load = 0, n_full = 0, n_tclr = 0;
  logic [W-1:0] got_load = '0;

  rtc_serial_port i_rtc_serial_port (
    .clk(clk), .rst_n(rst_n), .sel(sel), .dir(dir), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .snap_in(snap_in), .load_data(load_data),
    .load_pulse(load_pulse), .carry_hold(carry_hold), .div_clear(div_clear),
    .full_read(full_read), .test_clr(test_clr));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (load_pulse) begin n_load++; got_load = load_data; end
    if (full_read) n_full++;
    if (test_clr) n_tclr++;
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    sclk = 1; waitc(4); sclk = 0; waitc(4);
  endtask

  task automatic deselect();
    sel = 0; waitc(4);
  endtask

  function automatic logic [W-1:0] make_frame(input logic [7:0] s, mi, h, input logic [3:0] wd,
                                              input logic [7:0] d, mo, y);
    return {y, mo, d, wd, h, mi, s};
  endfunction

  task automatic do_read(input logic [W-1:0] f, input int nbits, output logic [W-1:0] rx);
    rx = '0;
    snap_in = f; dir = 0; sel = 1; waitc(2);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1; waitc(4);
      rx[i] = sdo;
      sclk = 0; waitc(4);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] rx;
    int b_load, b_full, b_tclr;
    waitc(3);
    // R12 reset state
    check(!sdo_oe && !sdo && !load_pulse && !full_read && !carry_hold && !div_clear && !test_clr,
          "R12 reset", {sdo_oe, sdo, load_pulse, full_read, carry_hold, div_clear}, '0);
    rst_n = 1; waitc(3);

    for (int v = 0; v < NV; v++) begin
      // R4 read full frame
      b_full = n_full;
      do_read(VEC[v], W, rx);
      check(rx == VEC[v], "R4 read bits", rx, VEC[v]);
      check(n_full == b_full + 1, "R6 full read pulse", n_full, b_full + 1);
      // R5 extra clocks leave sdo unchanged
      snap_in = ~VEC[v];
      for (int k = 0; k < 3; k++) begin
        pulse_sclk();
        check(sdo == VEC[v][W-1], "R5 read saturate", sdo, VEC[v][W-1]);
      end
      check(n_full == b_full + 1, "R6 single pulse", n_full, b_full + 1);
      b_tclr = n_tclr;
      deselect();
      check(n_tclr == b_tclr + 1, "R11 test clear", n_tclr, b_tclr + 1);

      // R7 write frame
      b_load = n_load;
      dir = 1; sel = 1; waitc(2);
      check(!sdo_oe, "R2 oe in write", sdo_oe, 0);
      for (int i = 0; i < W; i++) begin
        sdi = VEC[v][i];
        sclk = 1; waitc(4);
        if (i == 1) check(!div_clear && carry_hold, "R9 div clear ends", {carry_hold, div_clear}, 2);
        sclk = 0; waitc(4);
        if (i == 0) check(div_clear && carry_hold, "R9 R10 first fall", {carry_hold, div_clear}, 3);
      end
      check(n_load == b_load + 1 && got_load == VEC[v], "R7 commit", got_load, VEC[v]);
      for (int k = 0; k < 5; k++) begin sdi = ~VEC[v][k]; pulse_sclk(); end
      check(n_load == b_load + 1 && load_data == VEC[v], "R7 extra bits ignored", load_data, VEC[v]);
      check(carry_hold, "R10 hold persists", carry_hold, 1);
      deselect();
      check(!carry_hold, "R10 hold released", carry_hold, 0);
    end

    // R3 field layout via write, R6 partial read
    begin
      logic [W-1:0] f;
      f = make_frame(8'hD9, 8'h42, 8'h23, 4'h6, 8'h31, 8'h92, 8'h99);
      dir = 1; sel = 1; waitc(2);
      for (int i = 0; i < W; i++) begin sdi = f[i]; pulse_sclk(); end
      deselect();
      check(got_load[7] && got_load[6:0] == 7'h59 && got_load[15:8] == 8'h42 &&
            got_load[23:16] == 8'h23 && got_load[27:24] == 4'h6 && got_load[35:28] == 8'h31 &&
            got_load[43] && got_load[42:36] == 7'h12 && got_load[51:44] == 8'h99,
            "R3 field positions", got_load, f);
      b_full = n_full;
      do_read(f, 28, rx);
      check(rx[27:0] == f[27:0] && rx[27:24] == 4'h6, "R3 R4 partial read weekday", rx[27:0], f[27:0]);
      deselect();
      check(n_full == b_full, "R6 no pulse on partial read", n_full, b_full);
    end

    // R8 partial write
    b_load = n_load;
    dir = 1; sel = 1; waitc(2);
    for (int i = 0; i < 20; i++) begin sdi = i[0]; pulse_sclk(); end
    deselect();
    check(n_load == b_load, "R8 no commit", n_load, b_load);

    // R1 deselected activity
    b_load = n_load; b_full = n_full;
    for (int i = 0; i < 60; i++) begin dir = i[1]; sdi = i[0]; pulse_sclk(); end
    check(!sdo_oe && !carry_hold && !div_clear && n_load == b_load && n_full == b_full,
          "R1 deselected ignored", {sdo_oe, carry_hold, div_clear}, 0);
    // R1 position restarted: next read begins at bit 0
    do_read(VEC[0], 4, rx);
    check(rx[3:0] == VEC[0][3:0], "R1 restart at bit 0", rx[3:0], VEC[0][3:0]);

    // R2 output enable follows mode
    check(sdo_oe, "R2 oe in read", sdo_oe, 1);
    dir = 1; waitc(2);
    check(!sdo_oe, "R2 oe off on dir", sdo_oe, 0);
    deselect();
    check(!sdo_oe, "R2 oe off deselected", sdo_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule